// File: doc/BRIEF.md
# PLL Divider Chain Controller

This block holds the digital dividers that sit around a phase locked loop. A reference path picks either an internal reference clock, passed straight through, or an oscillator clock divided by a programmable ratio. A feedback divider turns the VCO clock into the comparison clock for the phase detector, at an even ratio set by a six-bit field. A post divider derives the PLL output clock from the VCO clock. A fixed divide-by-two stage then makes the bus clock from the PLL clock.

While the lock indicator is low, the post divider ignores its field and divides by four. This keeps the output slow while the loop settles. The lock indicator is brought into the VCO domain through a synchronizer before it selects the ratio. Each divider fetches a new ratio only when its current output period ends, so a change never cuts a period short. The analog VCO and the phase detector are outside the block; the VCO clock arrives as an input.

Top module: `pll_div_chain`

## Requirements
- R1: With `osc_en` = 0, `ref_clk` follows `irc_clk` at all times, and `ref_div` has no effect.
- R2: With `osc_en` = 1, one `ref_clk` period lasts exactly `ref_div`+1 `osc_clk` periods (1 to 16). A ratio of 1 gives `ref_clk` the period of `osc_clk`.
- R3: One `fb_clk` period lasts exactly 2*(`syn_div`+1) `vco_clk` periods (2 to 128).
- R4: With `pll_lock` = 1, one `pll_clk` period lasts exactly `post_div`+1 `vco_clk` periods (1 to 32).
- R5: With `pll_lock` = 0, one `pll_clk` period lasts exactly 4 `vco_clk` periods, whatever `post_div` holds.
- R6: One `bus_clk` period lasts exactly 2 `pll_clk` periods.
- R7: With `syn_div` = 0x18 and `post_div` = 3 while locked, `fb_clk` runs at 1/50 of the VCO rate, `pll_clk` at 1/4 and `bus_clk` at 1/8.
- R8: A divider field written in the middle of an output period does not change that period. The next period uses the new ratio.
- R9: While `rst` is high, `fb_clk`, `pll_clk` and `bus_clk` are low, and so is `ref_clk` when `osc_en` = 1. Raising `rst` forces them low at once, with no clock edge needed.
- R10: When `pll_lock` toggles at any time, every `pll_clk` period has the length of either the old ratio or the new ratio, with no shortened pulse. `pll_lock` passes through a two-stage synchronizer in the `vco_clk` domain before it changes the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset for all dividers, active high |
| osc_clk | input | 1 | Oscillator clock |
| irc_clk | input | 1 | Internal reference clock |
| osc_en | input | 1 | 1 selects the divided oscillator as the reference |
| ref_div | input | 4 | Reference ratio minus one |
| vco_clk | input | 1 | VCO clock |
| syn_div | input | 6 | Feedback half-ratio minus one |
| post_div | input | 5 | Post ratio minus one, used while locked |
| pll_lock | input | 1 | Lock indicator, asynchronous to `vco_clk` |
| ref_clk | output | 1 | Reference clock to the phase detector |
| fb_clk | output | 1 | Divided VCO clock to the phase detector |
| pll_clk | output | 1 | PLL output clock |
| bus_clk | output | 1 | PLL clock divided by two |

## Verification
The bench measures output periods against the extremes of each field. These are ratio 1, where a counter-based divider without a bypass would stall or halve the clock, and the largest ratios, where a counter one bit too narrow would wrap early. It also runs the example setting with a ratio of 50 and an unlocked case with a large `post_div`, which a design that left the field active would divide wrongly. A field is changed just after a `pll_clk` edge: a design that loads ratios at once would shorten the current period. The bench then toggles `pll_lock` at times unrelated to the clock and looks for runt periods. It also asserts `rst` between clock edges to catch a reset that waits for a clock that no longer runs.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned MAX_CW = 15;

  // number of input cycles the output stays high: ceil(ratio/2), ratio = m1+1
  function automatic logic [MAX_CW:0] high_len(input logic [MAX_CW:0] m1);
    logic [MAX_CW+1:0] s;
    s = {1'b0, m1} + (MAX_CW+2)'(2);
    return s[MAX_CW+1:1];
  endfunction
endpackage

// File: rtl/clk_div.sv
module clk_div
  import pll_div_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_m1,
  output logic          clk_out
);
  logic [CW-1:0] cnt, cur_m1;
  logic [CW-1:0] nxt_cnt, nxt_m1;
  logic [MAX_CW:0] hlen;
  logic          wrap, q, byp;

  assign wrap    = (cnt == cur_m1);
  assign nxt_cnt = wrap ? '0 : cnt + CW'(1);
  assign nxt_m1  = wrap ? ratio_m1 : cur_m1;
  assign hlen    = high_len((MAX_CW+1)'(nxt_m1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      cur_m1 <= '0;
      q      <= 1'b0;
      byp    <= 1'b0;
    end else begin
      cnt    <= nxt_cnt;
      cur_m1 <= nxt_m1;
      q      <= ((MAX_CW+1)'(nxt_cnt) < hlen);
      byp    <= (nxt_m1 == '0);
    end
  end

  // ratio 1: the input clock is passed through; switching happens on a rising edge
  assign clk_out = byp ? clk : q;

  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= cur_m1);

  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt != cur_m1) |=> $stable(cur_m1));

  assert_last_cycle_low_R3: assert property (@(posedge clk) disable iff (rst)
    ((cnt == cur_m1) && (cur_m1 != '0)) |-> !q);

  assert_bypass_ratio_one_R2: assert property (@(posedge clk) disable iff (rst)
    byp |-> (cur_m1 == '0));
endmodule

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_in,
  output logic lock_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= lock_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign lock_out = chain[STAGES-1];

  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_out) |-> $past(lock_in, STAGES));
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int unsigned REF_W        = 4,
  parameter int unsigned SYN_W        = 6,
  parameter int unsigned POST_W       = 5,
  parameter int unsigned UNLOCK_RATIO = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              rst,
  input  logic              osc_clk,
  input  logic              irc_clk,
  input  logic              osc_en,
  input  logic [REF_W-1:0]  ref_div,
  input  logic              vco_clk,
  input  logic [SYN_W-1:0]  syn_div,
  input  logic [POST_W-1:0] post_div,
  input  logic              pll_lock,
  output logic              ref_clk,
  output logic              fb_clk,
  output logic              pll_clk,
  output logic              bus_clk
);
  localparam int unsigned FB_W = SYN_W + 1;
  localparam logic [POST_W-1:0] UNLOCK_M1 = POST_W'(UNLOCK_RATIO - 1);

  logic              osc_div_clk;
  logic              lock_v;
  logic [FB_W-1:0]   fb_m1;
  logic [POST_W-1:0] post_m1;

  clk_div #(.CW(REF_W)) u_ref_div (
    .clk(osc_clk), .rst(rst), .ratio_m1(ref_div), .clk_out(osc_div_clk)
  );

  assign ref_clk = osc_en ? osc_div_clk : irc_clk;

  // feedback ratio 2*(syn+1): ratio minus one is 2*syn+1
  assign fb_m1 = {syn_div, 1'b1};

  clk_div #(.CW(FB_W)) u_fb_div (
    .clk(vco_clk), .rst(rst), .ratio_m1(fb_m1), .clk_out(fb_clk)
  );

  lock_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(vco_clk), .rst(rst), .lock_in(pll_lock), .lock_out(lock_v)
  );

  assign post_m1 = lock_v ? post_div : UNLOCK_M1;

  clk_div #(.CW(POST_W)) u_post_div (
    .clk(vco_clk), .rst(rst), .ratio_m1(post_m1), .clk_out(pll_clk)
  );

  clk_div #(.CW(1)) u_bus_div (
    .clk(pll_clk), .rst(rst), .ratio_m1(1'b1), .clk_out(bus_clk)
  );
endmodule

// File: tb/pll_div_chain_tb.sv
`timescale 1ns/1ps
module pll_div_chain_tb;
  localparam real VCO_NS = 4.0;
  localparam real OSC_NS = 10.0;
  localparam real IRC_NS = 16.0;

  logic rst = 1'b1, osc_clk = 1'b0, irc_clk = 1'b0, vco_clk = 1'b0;
  logic osc_en = 1'b1, pll_lock = 1'b0;
  logic [3:0] ref_div = '0;
  logic [5:0] syn_div = '0;
  logic [4:0] post_div = '0;
  logic ref_clk, fb_clk, pll_clk, bus_clk;

  always #(VCO_NS/2) vco_clk = ~vco_clk;
  always #(OSC_NS/2) osc_clk = ~osc_clk;
  always #(IRC_NS/2) irc_clk = ~irc_clk;

  pll_div_chain u_dut (
    .rst(rst), .osc_clk(osc_clk), .irc_clk(irc_clk), .osc_en(osc_en),
    .ref_div(ref_div), .vco_clk(vco_clk), .syn_div(syn_div),
    .post_div(post_div), .pll_lock(pll_lock), .ref_clk(ref_clk),
    .fb_clk(fb_clk), .pll_clk(pll_clk), .bus_clk(bus_clk)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  realtime t_ref = -1, t_fb = -1, t_pll = -1, t_bus = -1;
  realtime p_ref = 0, p_fb = 0, p_pll = 0, p_bus = 0;
  int n_ref = 0, n_fb = 0, n_pll = 0, n_bus = 0;
  bit mon = 0; int mon_bad = 0; bit saw_a = 0, saw_b = 0;

  always @(posedge ref_clk) begin
    if (t_ref >= 0) p_ref = $realtime - t_ref;
    t_ref = $realtime; n_ref++;
  end
  always @(posedge fb_clk) begin
    if (t_fb >= 0) p_fb = $realtime - t_fb;
    t_fb = $realtime; n_fb++;
  end
  always @(posedge pll_clk) begin
    if (t_pll >= 0) p_pll = $realtime - t_pll;
    t_pll = $realtime; n_pll++;
    if (mon) begin
      if (p_pll > 15.99 && p_pll < 16.01) saw_a = 1;
      else if (p_pll > 27.99 && p_pll < 28.01) saw_b = 1;
      else mon_bad++;
    end
  end
  always @(posedge bus_clk) begin
    if (t_bus >= 0) p_bus = $realtime - t_bus;
    t_bus = $realtime; n_bus++;
  end

  task automatic chk(string req, string what, real got, real exp);
    n_chk++;
    if (got < exp - 0.01 || got > exp + 0.01) begin
      n_fail++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, got, exp);
    end
  endtask

  task automatic fresh_periods();
    int s_ref, s_fb, s_pll, s_bus;
    s_ref = n_ref; s_fb = n_fb; s_pll = n_pll; s_bus = n_bus;
    wait (n_ref >= s_ref + 2 && n_fb >= s_fb + 2 &&
          n_pll >= s_pll + 2 && n_bus >= s_bus + 2);
    #1;
  endtask

  typedef struct packed {
    logic       osc;
    logic [3:0] rd;
    logic [5:0] sd;
    logic [4:0] pd;
    logic       lk;
    logic [7:0] e_ref_ns;
    logic [7:0] e_fb;
    logic [7:0] e_pll;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0,  6'd0,  5'd0,  1'b1, 8'd10,  8'd2,   8'd1},
    '{1'b1, 4'd15, 6'd63, 5'd31, 1'b1, 8'd160, 8'd128, 8'd32},
    '{1'b1, 4'd2,  6'd24, 5'd3,  1'b1, 8'd30,  8'd50,  8'd4},
    '{1'b1, 4'd4,  6'd5,  5'd2,  1'b1, 8'd50,  8'd12,  8'd3},
    '{1'b0, 4'd7,  6'd1,  5'd6,  1'b1, 8'd16,  8'd4,   8'd7},
    '{1'b1, 4'd1,  6'd2,  5'd9,  1'b0, 8'd20,  8'd6,   8'd4},
    '{1'b1, 4'd0,  6'd24, 5'd3,  1'b0, 8'd10,  8'd50,  8'd4},
    '{1'b1, 4'd9,  6'd3,  5'd4,  1'b1, 8'd100, 8'd8,   8'd5}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R9: outputs held low under reset while clocks run
    #60.3;
    chk("R9", "ref_clk in reset", real'(ref_clk), 0.0);
    chk("R9", "fb_clk in reset", real'(fb_clk), 0.0);
    chk("R9", "pll_clk in reset", real'(pll_clk), 0.0);
    chk("R9", "bus_clk in reset", real'(bus_clk), 0.0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      osc_en = VEC[i].osc; ref_div = VEC[i].rd; syn_div = VEC[i].sd;
      post_div = VEC[i].pd; pll_lock = VEC[i].lk;
      #1200.3;
      fresh_periods();
      chk(VEC[i].osc ? "R2" : "R1", "ref period", p_ref, real'(VEC[i].e_ref_ns));
      chk(i == 2 || i == 6 ? "R7" : "R3", "fb period", p_fb, real'(VEC[i].e_fb) * VCO_NS);
      chk(VEC[i].lk ? "R4" : "R5", "pll period", p_pll, real'(VEC[i].e_pll) * VCO_NS);
      chk("R6", "bus period", p_bus, 2.0 * real'(VEC[i].e_pll) * VCO_NS);
      if (!VEC[i].osc) begin
        for (int k = 0; k < 5; k++) begin
          #3.7;
          chk("R1", "ref_clk level vs irc_clk", real'(ref_clk), real'(irc_clk));
        end
      end
    end

    // R8: change post_div right after an output edge; current period keeps old ratio
    pll_lock = 1'b1; post_div = 5'd31;
    #1200.3;
    @(posedge pll_clk); #6.3;
    post_div = 5'd1;
    @(posedge pll_clk); #1;
    chk("R8", "period during change", p_pll, 32.0 * VCO_NS);
    @(posedge pll_clk); #1;
    chk("R8", "period after change", p_pll, 2.0 * VCO_NS);

    // R10: asynchronous lock toggling, only 4- or 7-cycle periods allowed
    post_div = 5'd6; pll_lock = 1'b1;
    #400.3;
    mon = 1;
    for (int k = 0; k < 8; k++) begin
      #(151.7 + 13.3 * k);
      pll_lock = ~pll_lock;
    end
    #300.1;
    mon = 0;
    chk("R10", "runt periods across lock toggles", real'(mon_bad), 0.0);
    chk("R10", "both ratios seen", real'(saw_a && saw_b), 1.0);

    // R9: asynchronous reset between edges
    osc_en = 1'b1; ref_div = 4'd3;
    #200.3;
    rst = 1'b1;
    #0.4;
    chk("R9", "fb_clk after async reset", real'(fb_clk), 0.0);
    chk("R9", "pll_clk after async reset", real'(pll_clk), 0.0);
    chk("R9", "bus_clk after async reset", real'(bus_clk), 0.0);
    chk("R9", "ref_clk after async reset", real'(ref_clk), 0.0);
    finish_run();
  end
endmodule